// File: doc/BRIEF.md
# Row/Column Multiplexing DRAM Controller with Refresh

This block sits between a simple synchronous client port and a DRAM array that has 2048 rows, 2048 columns and a 4-bit word at each location. The client presents a 22-bit cell address. The controller splits it into a row part and a column part and sends both over one 11-bit address bus, row first and column second. The row strobe and the column strobe frame each half. Write data and read data use separate buses on the array side. The client sees a ready signal for acceptance and a one-cycle valid pulse when read data returns.

Reading a DRAM cell destroys its charge, so every row must be activated regularly to sense and restore it. An internal timer raises a refresh request at a fixed period. A row counter picks the next row, and the controller activates that row with the row strobe alone, with no column strobe. While a refresh is pending or running, client requests are stalled. An access that has already started always runs to completion first.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: The row is address bits [21:11] and the column is bits [10:0]. The row is driven on `ma_o` first and the column second.
- R2: The row address is on `ma_o` for one full cycle before `ras_n_o` falls, and `ma_o` does not change on the cycle the row strobe falls.
- R3: The column address is placed while `ras_n_o` is low. `cas_n_o` falls one cycle later and is only ever low while `ras_n_o` is low.
- R4: `cas_n_o` stays low for exactly TCAS cycles per access.
- R5: After every access or refresh, `ras_n_o` and `cas_n_o` are both high for at least TRP cycles before `ras_n_o` falls again.
- R6: After a read is accepted on a rising edge, `rvalid_o` pulses high for one cycle, exactly TCAS+3 edges later, with the stored 4-bit word on `rdata_o`.
- R7: For a write, `dwe_n_o` is low, `dq_oe_o` is high and `dq_o` equals the write data while `cas_n_o` is low. A later read of the same address returns that data.
- R8: A refresh request arises every REFRESH_INTERVAL cycles. Each request yields one refresh: a row strobe with no column strobe.
- R9: Refreshed rows start at 0 after reset, go up by one per refresh, and wrap from 2047 to 0.
- R10: `ready_o` is low while a refresh is pending or running. A pending refresh wins over a waiting client request, but an access already in progress finishes first.
- R11: During and right after reset, `ras_n_o`, `cas_n_o` and `dwe_n_o` are high, `rvalid_o` is low and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Client request, accepted on an edge where `ready_o` is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 22 | Cell address, row in [21:11], column in [10:0] |
| wdata_i | input | 4 | Write data |
| ready_o | output | 1 | Controller can accept a request this cycle |
| rdata_o | output | 4 | Read data, valid while `rvalid_o` is high |
| rvalid_o | output | 1 | One-cycle read-data valid pulse |
| ma_o | output | 11 | Multiplexed row/column address to the array |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| dwe_n_o | output | 1 | Array write enable, active low |
| dq_o | output | 4 | Data to the array |
| dq_oe_o | output | 1 | Data output enable toward the array |
| dq_i | input | 4 | Data from the array, sampled at the end of the column strobe |

## Verification
The assertions assume that the array presents read data on `dq_i` while the column strobe is low, and that the client holds its request fields stable until acceptance. The bench drives requests only at falling edges and holds them until `ready_o` is seen, so acceptance is unambiguous. It runs one access at a time against a behavioural array that latches the row on the row strobe fall and the column on the column strobe fall. Random addresses come from a small pool plus the two corner addresses, so reads often hit earlier writes. The run lasts long enough for the refresh row counter to wrap.

// File: rtl/dramc_pkg.sv
// Package: shared state encoding for the DRAM controller.
// Assumes: one access or refresh in flight at a time.
package dramc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RADDR    = 3'd1,
        ST_RSTB     = 3'd2,
        ST_CADDR    = 3'd3,
        ST_CSTB     = 3'd4,
        ST_PRE      = 3'd5,
        ST_REF_ADDR = 3'd6,
        ST_REF_STB  = 3'd7
    } dramc_state_e;
endpackage

// File: rtl/dramc_refresh_timer.sv
// Module: periodic refresh request generator.
// Raises pend_o every INTERVAL cycles; it stays high until acknowledged.
// Assumes: INTERVAL >= 2 and each refresh is served before the next period ends.
module dramc_refresh_timer #(
    parameter int INTERVAL = 390
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic pend_o
);
    localparam int TW = $clog2(INTERVAL);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == LAST);

    // Free-running period counter and sticky request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            pend_o <= 1'b0;
        end else begin
            cnt <= wrap ? '0 : cnt + 1'b1;
            if (wrap)
                pend_o <= 1'b1;
            else if (ack_i)
                pend_o <= 1'b0;
        end
    end

    // R8: a request is not dropped before the sequencer takes it.
    p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !ack_i) |=> pend_o);
endmodule

// File: rtl/dramc_refresh_rows.sv
// Module: row counter for refresh; advances once per finished refresh.
// Assumes: adv_i pulses for one cycle at the end of each refresh.
module dramc_refresh_rows #(
    parameter int ROW_BITS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv_i,
    output logic [ROW_BITS-1:0] row_o
);
    // Step to the next row, wrapping naturally at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_o <= '0;
        else if (adv_i)
            row_o <= row_o + 1'b1;
    end
endmodule

// File: rtl/dramc_sequencer.sv
// Module: strobe sequencer for multiplexed-address DRAM access and refresh.
// Access: row addr -> row strobe -> col addr -> col strobe (TCAS) -> precharge (TRP).
// Refresh: row addr -> row strobe only (HOLD cycles) -> precharge (TRP).
// Assumes: dq_i holds read data while the column strobe is low.
module dramc_sequencer
    import dramc_pkg::*;
#(
    parameter int ROW_BITS = 11,
    parameter int COL_BITS = 11,
    parameter int DATA_W   = 4,
    parameter int TCAS     = 2,
    parameter int TRP      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                we_i,
    input  logic [ROW_BITS-1:0] row_i,
    input  logic [COL_BITS-1:0] col_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic                ready_o,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                rvalid_o,
    input  logic                ref_pend_i,
    input  logic [ROW_BITS-1:0] ref_row_i,
    output logic                ref_ack_o,
    output logic                ref_done_o,
    output logic [ROW_BITS-1:0] ma_o,
    output logic                ras_n_o,
    output logic                cas_n_o,
    output logic                dwe_n_o,
    output logic [DATA_W-1:0]   dq_o,
    output logic                dq_oe_o,
    input  logic [DATA_W-1:0]   dq_i
);
    localparam int HOLD   = TCAS + 2;
    localparam int MAXT   = (HOLD > TRP) ? HOLD : TRP;
    localparam int CW     = $clog2(MAXT + 1) + 1;
    localparam logic [CW-1:0] TCAS_M1 = CW'(TCAS - 1);
    localparam logic [CW-1:0] TRP_M1  = CW'(TRP - 1);
    localparam logic [CW-1:0] HOLD_M1 = CW'(HOLD - 1);

    dramc_state_e          state;
    logic [CW-1:0]         tcnt;
    logic [ROW_BITS-1:0]   row_q;
    logic [COL_BITS-1:0]   col_q;
    logic                  we_q;
    logic [DATA_W-1:0]     wd_q;
    logic                  col_phase;
    logic                  tdone;

    assign tdone     = (tcnt == '0);
    assign col_phase = (state == ST_CADDR) || (state == ST_CSTB);

    // Main sequence: accept, strobe, hold, precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tcnt     <= '0;
            row_q    <= '0;
            col_q    <= '0;
            we_q     <= 1'b0;
            wd_q     <= '0;
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ref_pend_i) begin
                        state <= ST_REF_ADDR;
                        row_q <= ref_row_i;
                        we_q  <= 1'b0;
                    end else if (req_i) begin
                        state <= ST_RADDR;
                        row_q <= row_i;
                        col_q <= col_i;
                        we_q  <= we_i;
                        wd_q  <= wdata_i;
                    end
                end
                ST_RADDR: state <= ST_RSTB;
                ST_RSTB:  state <= ST_CADDR;
                ST_CADDR: begin
                    state <= ST_CSTB;
                    tcnt  <= TCAS_M1;
                end
                ST_CSTB: begin
                    if (tdone) begin
                        state <= ST_PRE;
                        tcnt  <= TRP_M1;
                        if (!we_q) begin
                            rdata_o  <= dq_i;
                            rvalid_o <= 1'b1;
                        end
                    end else begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
                ST_REF_ADDR: begin
                    state <= ST_REF_STB;
                    tcnt  <= HOLD_M1;
                end
                ST_REF_STB: begin
                    if (tdone) begin
                        state <= ST_PRE;
                        tcnt  <= TRP_M1;
                    end else begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
                ST_PRE: begin
                    if (tdone)
                        state <= ST_IDLE;
                    else
                        tcnt <= tcnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake and refresh bookkeeping toward timer and row counter.
    always_comb begin
        ready_o    = (state == ST_IDLE) && !ref_pend_i;
        ref_ack_o  = (state == ST_IDLE) && ref_pend_i;
        ref_done_o = (state == ST_REF_STB) && tdone;
    end

    // Array-side pins decoded from state.
    always_comb begin
        ma_o    = col_phase ? ROW_BITS'(col_q) : row_q;
        ras_n_o = !((state == ST_RSTB) || col_phase || (state == ST_REF_STB));
        cas_n_o = !(state == ST_CSTB);
        dwe_n_o = !(we_q && col_phase);
        dq_oe_o = we_q && col_phase;
        dq_o    = wd_q;
    end

    // Checker-only count of cycles the row strobe has been high.
    logic [CW-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= CW'(TRP);
        else if (!ras_n_o)
            hi_cnt <= '0;
        else if (hi_cnt < CW'(TRP))
            hi_cnt <= hi_cnt + 1'b1;
    end

    // R2: address bus does not move on the cycle the row strobe falls.
    p_row_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> $stable(ma_o));
    // R3: column strobe only inside an active row.
    p_cas_in_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n_o |-> !ras_n_o);
    // R5: precharge gap before every new row strobe.
    p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> (hi_cnt >= CW'(TRP)));
    // R6: read valid is a single-cycle pulse.
    p_rvalid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> !rvalid_o);
    // R7: data is driven whenever the array write enable is active.
    p_wr_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dwe_n_o |-> dq_oe_o);
endmodule

// File: rtl/dram_refresh_ctrl.sv
// Module: top of the DRAM controller with periodic row refresh.
// Splits the cell address into row/column halves, sequences strobes,
// and interleaves refresh with client accesses (refresh wins when idle).
// Assumes: client holds request fields stable until accepted.
module dram_refresh_ctrl #(
    parameter int ROW_BITS         = 11,
    parameter int COL_BITS         = 11,
    parameter int DATA_W           = 4,
    parameter int TCAS             = 2,
    parameter int TRP              = 2,
    parameter int REFRESH_INTERVAL = 390
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_i,
    input  logic                         we_i,
    input  logic [ROW_BITS+COL_BITS-1:0] addr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic                         ready_o,
    output logic [DATA_W-1:0]            rdata_o,
    output logic                         rvalid_o,
    output logic [ROW_BITS-1:0]          ma_o,
    output logic                         ras_n_o,
    output logic                         cas_n_o,
    output logic                         dwe_n_o,
    output logic [DATA_W-1:0]            dq_o,
    output logic                         dq_oe_o,
    input  logic [DATA_W-1:0]            dq_i
);
    localparam int AW = ROW_BITS + COL_BITS;

    logic                ref_pend;
    logic                ref_ack;
    logic                ref_done;
    logic [ROW_BITS-1:0] ref_row;
    logic [ROW_BITS-1:0] req_row;
    logic [COL_BITS-1:0] req_col;

    // Address split: upper half selects the row, lower half the column.
    assign req_row = addr_i[AW-1:COL_BITS];
    assign req_col = addr_i[COL_BITS-1:0];

    dramc_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_i  (ref_ack),
        .pend_o (ref_pend)
    );

    dramc_refresh_rows #(.ROW_BITS(ROW_BITS)) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (ref_done),
        .row_o (ref_row)
    );

    dramc_sequencer #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .DATA_W   (DATA_W),
        .TCAS     (TCAS),
        .TRP      (TRP)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .we_i       (we_i),
        .row_i      (req_row),
        .col_i      (req_col),
        .wdata_i    (wdata_i),
        .ready_o    (ready_o),
        .rdata_o    (rdata_o),
        .rvalid_o   (rvalid_o),
        .ref_pend_i (ref_pend),
        .ref_row_i  (ref_row),
        .ref_ack_o  (ref_ack),
        .ref_done_o (ref_done),
        .ma_o       (ma_o),
        .ras_n_o    (ras_n_o),
        .cas_n_o    (cas_n_o),
        .dwe_n_o    (dwe_n_o),
        .dq_o       (dq_o),
        .dq_oe_o    (dq_oe_o),
        .dq_i       (dq_i)
    );

    // R10: no client handshake while a refresh waits.
    p_ref_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !ready_o);
endmodule

// File: tb/sim_dram_refresh_ctrl.sv
// Bench: random and directed accesses against a behavioural array model.
module sim_dram_refresh_ctrl;
    localparam int TCAS  = 2;
    localparam int TRP   = 2;
    localparam int RINT  = 20;
    localparam int SLACK = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [21:0] addr = '0;
    logic [3:0]  wdata = '0;
    logic        ready_o, rvalid_o, ras_n_o, cas_n_o, dwe_n_o, dq_oe_o;
    logic [3:0]  rdata_o, dq_o;
    logic [3:0]  dq_i = '0;
    logic [10:0] ma_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dram_refresh_ctrl #(.TCAS(TCAS), .TRP(TRP), .REFRESH_INTERVAL(RINT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .ready_o(ready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
        .ma_o(ma_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .dwe_n_o(dwe_n_o),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req_tag, act, exp, cyc);
        end
    endtask

    function automatic logic [3:0] init_val(input logic [21:0] a);
        return a[3:0] ^ a[15:12] ^ a[21:18];
    endfunction

    // Behavioural array and the bench's own expectation store.
    logic [3:0] arr [int unsigned];
    logic [3:0] shadow [int unsigned];

    function automatic logic [3:0] exp_read(input logic [21:0] a);
        return shadow.exists(a) ? shadow[a] : init_val(a);
    endfunction

    // Client-side state shared with the monitor.
    bit          op_active = 1'b0;
    logic [21:0] cur_addr = '0;
    logic        cur_we = 1'b0;
    logic [3:0]  cur_wd = '0;

    // Monitor state.
    logic        p_ras = 1'b1, p_cas = 1'b1;
    logic [10:0] p_ma = '0;
    logic [10:0] row_lat = '0;
    int          hi_len = 100, lo_len = 0;
    bit          in_ref = 1'b0, saw_cas = 1'b0;
    logic [10:0] exp_ref_row = '0;
    int          ref_count = 0, last_ref_cyc = 0, wrap_seen = 0;

    // Array model plus strobe-timing monitor, evaluated at falling edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !ras_n_o) begin
                chk(ma_o == p_ma, "R2 row addr stable at strobe", ma_o, p_ma);
                chk(hi_len >= TRP, "R5 precharge length", hi_len, TRP);
                row_lat = ma_o;
                saw_cas = 1'b0;
                in_ref  = !op_active;
                if (op_active)
                    chk(ma_o == cur_addr[21:11], "R1 row half", ma_o, cur_addr[21:11]);
                else begin
                    chk(ma_o == exp_ref_row, "R9 refresh row order", ma_o, exp_ref_row);
                    if (ref_count > 0)
                        chk((cyc - last_ref_cyc >= RINT - SLACK) && (cyc - last_ref_cyc <= RINT + SLACK),
                            "R8 refresh period", cyc - last_ref_cyc, RINT);
                    if (exp_ref_row == 11'd2047) wrap_seen++;
                    exp_ref_row = exp_ref_row + 11'd1;
                    last_ref_cyc = cyc;
                    ref_count++;
                end
            end
            if (!ras_n_o && in_ref)
                chk(ready_o == 1'b0, "R10 stalled during refresh", ready_o, 0);
            if (!cas_n_o) begin
                if (p_cas) begin
                    chk(!ras_n_o && !p_ras, "R3 column strobe under row strobe", ras_n_o, 0);
                    chk(ma_o == p_ma, "R3 column addr one cycle ahead", ma_o, p_ma);
                    chk(!in_ref, "R8 no column strobe in refresh", in_ref, 0);
                    if (op_active)
                        chk(ma_o == cur_addr[10:0], "R1 column half", ma_o, cur_addr[10:0]);
                end
                saw_cas = 1'b1;
                if (!dwe_n_o) begin
                    chk(dq_oe_o && dq_o == cur_wd && cur_we, "R7 write drive", dq_o, cur_wd);
                    arr[{row_lat, ma_o}] = dq_o;
                end else begin
                    dq_i = arr.exists({row_lat, ma_o}) ? arr[{row_lat, ma_o}] : init_val({row_lat, ma_o});
                end
                lo_len++;
            end else if (!p_cas) begin
                chk(lo_len == TCAS, "R4 column strobe length", lo_len, TCAS);
                lo_len = 0;
                op_active = 1'b0;
            end
            if (ras_n_o && !p_ras) begin
                if (in_ref) chk(!saw_cas, "R8 refresh has no column strobe", saw_cas, 0);
                in_ref = 1'b0;
            end
            hi_len = ras_n_o ? hi_len + 1 : 0;
            p_ras = ras_n_o;
            p_cas = cas_n_o;
            p_ma  = ma_o;
        end
    end

    task automatic do_op(input logic w, input logic [21:0] a, input logic [3:0] d);
        int acc;
        int guard;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        while (!ready_o) @(negedge clk);
        @(posedge clk);
        #1;
        acc = cyc;
        cur_addr = a; cur_we = w; cur_wd = d; op_active = 1'b1;
        if (w) shadow[a] = d;
        @(negedge clk);
        req = 1'b0;
        if (!w) begin
            guard = 0;
            while (!rvalid_o && guard < 40) begin
                @(negedge clk);
                guard++;
            end
            chk(cyc == acc + 3 + TCAS, "R6 read latency", cyc - acc, 3 + TCAS);
            chk(rdata_o == exp_read(a), "R6/R7 read data", rdata_o, exp_read(a));
            @(negedge clk);
            chk(!rvalid_o, "R6 single-cycle valid", rvalid_o, 0);
        end
    endtask

    logic [21:0] pool [16];

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(ras_n_o && cas_n_o && dwe_n_o, "R11 strobes idle in reset", {ras_n_o, cas_n_o, dwe_n_o}, 7);
        chk(!rvalid_o, "R11 valid low in reset", rvalid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_o && ras_n_o && !rvalid_o, "R11 ready after reset", ready_o, 1);

        // Directed corners.
        do_op(1'b1, 22'h3FFFFF, 4'hA);
        do_op(1'b0, 22'h3FFFFF, 4'h0);
        do_op(1'b1, 22'h000000, 4'h5);
        do_op(1'b0, 22'h000000, 4'h0);
        do_op(1'b0, 22'h2A5555, 4'h0);
        do_op(1'b1, 22'h000800, 4'h3);
        do_op(1'b0, 22'h000800, 4'h0);
        do_op(1'b0, 22'h000001, 4'h0);

        foreach (pool[i]) pool[i] = 22'($urandom);
        pool[0] = 22'h3FFFFF;
        pool[1] = 22'h000000;

        // Random mix until the refresh counter has wrapped.
        while (ref_count < 2052 && cyc < 150000) begin
            logic [21:0] a;
            a = pool[$urandom_range(15)];
            do_op(1'($urandom_range(1)), a, 4'($urandom));
            if ($urandom_range(7) == 0) repeat ($urandom_range(25)) @(negedge clk);
        end

        chk(wrap_seen >= 1, "R9 refresh row wrap 2047 to 0", wrap_seen, 1);
        chk(ref_count >= (cyc / RINT) - 3, "R8 refresh count", ref_count, cyc / RINT);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc >= 195000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<195000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule